// File: doc/BRIEF.md
# Mailbox Message Transmit Fragmenter

This block moves a byte message from a streaming source into the write window of a slot-based mailbox. Each message arrives with a length, an 8-bit host address and an 8-bit client address. The block splits the message into fragments. Each fragment is one 32-bit header slot followed by the payload, packed four bytes to a slot. Before it writes, the block waits until the mailbox reports enough free slots. It raises a one-cycle interrupt-generate pulse after each fragment, then looks at the peer's ready flag.

The fragment size is limited by two things: the mailbox depth and the 9-bit length field of the header. One slot of the buffer is always kept for the header. Only the final fragment of a message carries the completion flag. A message of zero length is rejected at once. A programmable cycle limit bounds each wait for free space. When the limit is exceeded, or when the peer drops ready, the transfer ends with an error code on a one-cycle done pulse.

Top module: `mbox_tx_fragmenter`

## Requirements
- R1: Each header slot has this layout: bit 31 is the last-fragment flag, bits 30:25 are zero, bits 24:16 are the fragment payload length in bytes, bits 15:8 are the host address and bits 7:0 are the client address.
- R2: Each fragment carries min(FMAX, bytes still unsent) bytes, where FMAX = min(4*DEPTH, 511) - 4. Bit 31 of the header is set only on the fragment that ends the message.
- R3: The header is written only in a cycle that follows a cycle in which `free_slots` was at least 1. No payload slot of a fragment is written until `free_slots` has reached ceil(length/4).
- R4: Payload bytes are packed in little-endian order: stream byte k of a slot goes to bits 8k+7:8k. Unused bytes of the last slot of a fragment are zero.
- R5: `irq_gen` pulses high for exactly one cycle per fragment, in the cycle right after the fragment's last slot is written.
- R6: If `peer_ready` is low in the cycle in which a fragment's last slot is written, the transfer ends with status 2 (peer not ready), `done` is high in the same cycle as that fragment's `irq_gen`, and nothing more is written.
- R7: A start with `msg_len` = 0 gives `done` with status 3 in the next cycle and writes nothing.
- R8: The wait for free space is timed. If the required space is still missing after `timeout_limit`+1 consecutive waiting cycles, the transfer ends with status 1 (timeout). No further slot and no `irq_gen` follow.
- R9: A completed message ends with a one-cycle `done` pulse and status 0. A `start` while `busy` is high is ignored.
- R10: After reset, `busy`, `done`, `wr_en`, `irq_gen` and `in_ready` are low. `in_ready` is high only while payload bytes are being taken, which implies `busy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a message (sampled while idle) |
| msg_len | input | MSG_LEN_W | Message length in bytes |
| host_addr | input | 8 | Host address for the headers |
| client_addr | input | 8 | Client address for the headers |
| timeout_limit | input | TO_W | Allowed waiting cycles for free space |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_ready | output | 1 | Block takes a byte this cycle |
| free_slots | input | $clog2(DEPTH+1) | Free slots reported by the mailbox |
| peer_ready | input | 1 | Peer ready flag |
| wr_en | output | 1 | Slot write strobe |
| wr_data | output | 32 | Slot write data |
| irq_gen | output | 1 | Interrupt-generate pulse after each fragment |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Transfer end pulse |
| status | output | 2 | 0 ok, 1 timeout, 2 peer not ready, 3 empty message |

## Verification
The bench builds two copies of the block. The first uses DEPTH=4, so the fragment cap is 12 bytes. This lets a sweep over every message length from 1 to 40 cross one, two, three and four fragment boundaries, with every possible tail of 1 to 4 bytes, and with several stall patterns on the stream. The second uses DEPTH=200, where the 511-byte length field sets the cap at 507 bytes instead of the depth. It covers lengths on either side of that cap and of twice that cap. The small copy also exercises waiting on header space and on payload space, both timeouts with their exact cycle counts, loss of peer ready, empty messages, and starts that arrive while busy.

// File: rtl/mbox_tx_pkg.sv
// Package: shared types and header layout for the mailbox transmit fragmenter.
// Assumes 32-bit slots and a 9-bit length field in the header.
package mbox_tx_pkg;

    typedef enum logic [1:0] {
        TX_OK        = 2'd0,
        TX_TIMEOUT   = 2'd1,
        TX_NOT_READY = 2'd2,
        TX_EMPTY     = 2'd3
    } tx_status_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_HDR,
        ST_WAIT_BODY,
        ST_BODY,
        ST_IRQ
    } tx_state_e;

    localparam int LEN_FIELD_MAX = 511;

    // Assemble a header slot from its fields.
    function automatic logic [31:0] build_hdr(input logic       last,
                                              input logic [8:0] len,
                                              input logic [7:0] host,
                                              input logic [7:0] client);
        return {last, 6'b0, len, host, client};
    endfunction

endpackage

// File: rtl/mbox_tx_timer.sv
// Module: wait-cycle counter for the transmit fragmenter.
// Counts consecutive cycles spent waiting for mailbox space. It flags expiry
// when the count equals the programmed limit. Clear has priority over count.
module mbox_tx_timer #(
    parameter int TO_W = 24
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr,
    input  logic            inc,
    input  logic [TO_W-1:0] limit,
    output logic            expired
);

    logic [TO_W-1:0] cnt_q;

    // Count waiting cycles, restart on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expiry once the count has reached the limit.
    always_comb begin
        expired = (cnt_q == limit);
    end

endmodule

// File: rtl/mbox_tx_packer.sv
// Module: byte-to-slot packer.
// Collects accepted bytes little-endian into a 32-bit slot. It emits the slot
// one cycle after the fourth byte, or after a byte marked as the fragment's
// last. Unfilled bytes are zero because the accumulator clears after each emit.
module mbox_tx_packer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        byte_take,
    input  logic [7:0]  byte_in,
    input  logic        byte_last,
    output logic        word_vld,
    output logic [31:0] word
);

    logic [31:0] acc_q;
    logic [1:0]  idx_q;
    logic [31:0] merged;

    // Place the incoming byte at its lane within the partial slot.
    always_comb begin
        merged = acc_q;
        merged[8*idx_q +: 8] = byte_in;
    end

    // Accumulate bytes and emit a slot when full or at fragment end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q    <= '0;
            idx_q    <= '0;
            word_vld <= 1'b0;
            word     <= '0;
        end else begin
            word_vld <= 1'b0;
            if (byte_take) begin
                if (idx_q == 2'd3 || byte_last) begin
                    word     <= merged;
                    word_vld <= 1'b1;
                    acc_q    <= '0;
                    idx_q    <= '0;
                end else begin
                    acc_q <= merged;
                    idx_q <= idx_q + 2'd1;
                end
            end
        end
    end

endmodule

// File: rtl/mbox_tx_ctrl.sv
// Module: fragment sequencer.
// Splits a message into fragments no larger than the cap. Waits for header and
// payload space, issues the header, paces the payload bytes, then raises
// interrupt-generate and checks peer ready. Assumes MSG_LEN_W >= 9 and DEPTH >= 2.
module mbox_tx_ctrl
    import mbox_tx_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int MSG_LEN_W = 16,
    parameter int TO_W      = 24,
    parameter int SLOT_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [MSG_LEN_W-1:0] msg_len,
    input  logic [7:0]           host_addr,
    input  logic [7:0]           client_addr,
    input  logic [TO_W-1:0]      timeout_limit,
    input  logic [SLOT_W-1:0]    free_slots,
    input  logic                 peer_ready,
    input  logic                 byte_take,
    output logic                 take_en,
    output logic                 take_last,
    output logic                 hdr_wr,
    output logic [31:0]          hdr_word,
    output logic                 irq_gen,
    output logic                 busy,
    output logic                 done,
    output tx_status_e           status,
    output logic                 tmr_clr,
    output logic                 tmr_inc,
    output logic [TO_W-1:0]      tmr_limit,
    input  logic                 tmr_exp
);

    localparam int RAW_BYTES = DEPTH * 4;
    localparam int LEN_CAP   = (RAW_BYTES < LEN_FIELD_MAX) ? RAW_BYTES : LEN_FIELD_MAX;
    localparam int FRAG_MAX  = LEN_CAP - 4;

    tx_state_e              state_q;
    logic [MSG_LEN_W-1:0]   rem_q;
    logic [8:0]             frag_q;
    logic [8:0]             left_q;
    logic                   last_q;
    logic [7:0]             host_q;
    logic [7:0]             client_q;
    logic [31:0]            need_slots;
    logic [31:0]            have_slots;
    logic                   hdr_room;
    logic                   body_room;

    // Size of the next fragment for a given remaining byte count.
    function automatic logic [8:0] frag_of(input logic [MSG_LEN_W-1:0] rem);
        if (rem > MSG_LEN_W'(FRAG_MAX)) begin
            return 9'(FRAG_MAX);
        end
        return 9'(rem);
    endfunction

    // Space tests against the mailbox free count.
    always_comb begin
        need_slots = (32'(frag_q) + 32'd3) >> 2;
        have_slots = 32'(free_slots);
        hdr_room   = (have_slots != 32'd0);
        body_room  = (have_slots >= need_slots);
    end

    // Stream handshake and timer control derived from the current state.
    always_comb begin
        take_en   = (state_q == ST_BODY);
        take_last = (left_q == 9'd1);
        busy      = (state_q != ST_IDLE);
        tmr_inc   = ((state_q == ST_WAIT_HDR)  && !hdr_room  && !tmr_exp) ||
                    ((state_q == ST_WAIT_BODY) && !body_room && !tmr_exp);
        tmr_clr   = !((state_q == ST_WAIT_HDR) || (state_q == ST_WAIT_BODY)) ||
                    ((state_q == ST_WAIT_HDR) && hdr_room);
    end

    // Sequence the fragments and register every outward strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rem_q     <= '0;
            frag_q    <= '0;
            left_q    <= '0;
            last_q    <= 1'b0;
            host_q    <= '0;
            client_q  <= '0;
            tmr_limit <= '0;
            hdr_wr    <= 1'b0;
            hdr_word  <= '0;
            irq_gen   <= 1'b0;
            done      <= 1'b0;
            status    <= TX_OK;
        end else begin
            hdr_wr  <= 1'b0;
            irq_gen <= 1'b0;
            done    <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        host_q    <= host_addr;
                        client_q  <= client_addr;
                        tmr_limit <= timeout_limit;
                        if (msg_len == '0) begin
                            done   <= 1'b1;
                            status <= TX_EMPTY;
                        end else begin
                            rem_q   <= msg_len;
                            frag_q  <= frag_of(msg_len);
                            last_q  <= (msg_len <= MSG_LEN_W'(FRAG_MAX));
                            state_q <= ST_WAIT_HDR;
                        end
                    end
                end
                ST_WAIT_HDR: begin
                    if (hdr_room) begin
                        hdr_wr   <= 1'b1;
                        hdr_word <= build_hdr(last_q, frag_q, host_q, client_q);
                        state_q  <= ST_WAIT_BODY;
                    end else if (tmr_exp) begin
                        done    <= 1'b1;
                        status  <= TX_TIMEOUT;
                        state_q <= ST_IDLE;
                    end
                end
                ST_WAIT_BODY: begin
                    if (body_room) begin
                        left_q  <= frag_q;
                        state_q <= ST_BODY;
                    end else if (tmr_exp) begin
                        done    <= 1'b1;
                        status  <= TX_TIMEOUT;
                        state_q <= ST_IDLE;
                    end
                end
                ST_BODY: begin
                    if (byte_take) begin
                        left_q <= left_q - 9'd1;
                        rem_q  <= rem_q - 1'b1;
                        if (left_q == 9'd1) begin
                            state_q <= ST_IRQ;
                        end
                    end
                end
                ST_IRQ: begin
                    irq_gen <= 1'b1;
                    if (!peer_ready) begin
                        done    <= 1'b1;
                        status  <= TX_NOT_READY;
                        state_q <= ST_IDLE;
                    end else if (last_q) begin
                        done    <= 1'b1;
                        status  <= TX_OK;
                        state_q <= ST_IDLE;
                    end else begin
                        frag_q  <= frag_of(rem_q);
                        last_q  <= (rem_q <= MSG_LEN_W'(FRAG_MAX));
                        state_q <= ST_WAIT_HDR;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mbox_tx_fragmenter.sv
// Module: mailbox message transmit fragmenter (top).
// Joins the sequencer, the byte packer and the wait timer. Header and payload
// writes never coincide, so the write port is a simple merge of both sources.
// Assumes the mailbox's free count reflects completed writes.
module mbox_tx_fragmenter
    import mbox_tx_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int MSG_LEN_W = 16,
    parameter int TO_W      = 24,
    localparam int SLOT_W   = $clog2(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [MSG_LEN_W-1:0] msg_len,
    input  logic [7:0]           host_addr,
    input  logic [7:0]           client_addr,
    input  logic [TO_W-1:0]      timeout_limit,
    input  logic                 in_valid,
    input  logic [7:0]           in_data,
    output logic                 in_ready,
    input  logic [SLOT_W-1:0]    free_slots,
    input  logic                 peer_ready,
    output logic                 wr_en,
    output logic [31:0]          wr_data,
    output logic                 irq_gen,
    output logic                 busy,
    output logic                 done,
    output logic [1:0]           status
);

    logic            byte_take;
    logic            take_en;
    logic            take_last;
    logic            hdr_wr;
    logic [31:0]     hdr_word;
    logic            pk_vld;
    logic [31:0]     pk_word;
    logic            tmr_clr;
    logic            tmr_inc;
    logic            tmr_exp;
    logic [TO_W-1:0] tmr_limit;
    tx_status_e      status_e;

    // Stream handshake and write-port merge.
    always_comb begin
        in_ready  = take_en;
        byte_take = in_valid && take_en;
        wr_en     = hdr_wr || pk_vld;
        wr_data   = hdr_wr ? hdr_word : pk_word;
        status    = status_e;
    end

    mbox_tx_ctrl #(
        .DEPTH     (DEPTH),
        .MSG_LEN_W (MSG_LEN_W),
        .TO_W      (TO_W),
        .SLOT_W    (SLOT_W)
    ) u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .msg_len       (msg_len),
        .host_addr     (host_addr),
        .client_addr   (client_addr),
        .timeout_limit (timeout_limit),
        .free_slots    (free_slots),
        .peer_ready    (peer_ready),
        .byte_take     (byte_take),
        .take_en       (take_en),
        .take_last     (take_last),
        .hdr_wr        (hdr_wr),
        .hdr_word      (hdr_word),
        .irq_gen       (irq_gen),
        .busy          (busy),
        .done          (done),
        .status        (status_e),
        .tmr_clr       (tmr_clr),
        .tmr_inc       (tmr_inc),
        .tmr_limit     (tmr_limit),
        .tmr_exp       (tmr_exp)
    );

    mbox_tx_packer u_packer (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_take (byte_take),
        .byte_in   (in_data),
        .byte_last (take_last),
        .word_vld  (pk_vld),
        .word      (pk_word)
    );

    mbox_tx_timer #(
        .TO_W (TO_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .inc     (tmr_inc),
        .limit   (tmr_limit),
        .expired (tmr_exp)
    );

endmodule

// File: rtl/mbox_tx_fragmenter_chk.sv
// Module: port-level property checker for the transmit fragmenter, bound to the top.
// Tracks on its own whether the next write must be a header.
module mbox_tx_fragmenter_chk #(
    parameter int DEPTH     = 16,
    parameter int MSG_LEN_W = 16,
    localparam int SLOT_W   = $clog2(DEPTH + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 start,
    input logic [MSG_LEN_W-1:0] msg_len,
    input logic                 in_ready,
    input logic [SLOT_W-1:0]    free_slots,
    input logic                 wr_en,
    input logic                 irq_gen,
    input logic                 busy,
    input logic                 done,
    input logic [1:0]           status
);

    logic expect_hdr;

    // Next write after an accepted start or a fragment end is a header.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            expect_hdr <= 1'b0;
        end else if (start && !busy && msg_len != '0) begin
            expect_hdr <= 1'b1;
        end else if (irq_gen) begin
            expect_hdr <= 1'b1;
        end else if (wr_en) begin
            expect_hdr <= 1'b0;
        end
    end

    a_r3_hdr_space: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && expect_hdr) |-> ($past(free_slots) != '0));

    a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_gen |=> !irq_gen);

    a_r6_nr_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd2) |-> irq_gen);

    a_r7_empty_reject: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && msg_len == '0) |=> (done && status == 2'd3 && !wr_en));

    a_r8_no_irq_timeout: assert property (@(posedge clk) disable iff (!rst_n)
        (done && status == 2'd1) |-> !irq_gen);

    a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r10_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy);

endmodule

bind mbox_tx_fragmenter mbox_tx_fragmenter_chk #(
    .DEPTH     (DEPTH),
    .MSG_LEN_W (MSG_LEN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .msg_len    (msg_len),
    .in_ready   (in_ready),
    .free_slots (free_slots),
    .wr_en      (wr_en),
    .irq_gen    (irq_gen),
    .busy       (busy),
    .done       (done),
    .status     (status)
);

// File: tb/mbox_tx_harness.sv
// Stimulus and checking for one configuration of the fragmenter.
module mbox_tx_harness #(
    parameter int DEPTH = 4,
    parameter int ID    = 0
) (
    input  logic clk,
    input  logic rst_n,
    output int   runs,
    output int   fails,
    output logic finished
);

    localparam int SW   = $clog2(DEPTH + 1);
    localparam int RAWB = DEPTH * 4;
    localparam int CAPB = ((RAWB < 511) ? RAWB : 511) - 4;

    logic          start = 1'b0;
    logic [15:0]   msg_len = '0;
    logic [7:0]    host = '0;
    logic [7:0]    client = '0;
    logic [23:0]   tlim = '0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = '0;
    logic          in_ready;
    logic [SW-1:0] free_slots = SW'(DEPTH);
    logic          peer_ready = 1'b1;
    logic          wr_en;
    logic [31:0]   wr_data;
    logic          irq;
    logic          busy;
    logic          done;
    logic [1:0]    status;

    logic [31:0] cap_q[$];
    int          irqs;
    logic        acc_flag = 1'b0;

    mbox_tx_fragmenter #(
        .DEPTH     (DEPTH),
        .MSG_LEN_W (16),
        .TO_W      (24)
    ) i_mbox_tx_fragmenter (
        .clk           (clk),
        .rst_n         (rst_n),
        .start         (start),
        .msg_len       (msg_len),
        .host_addr     (host),
        .client_addr   (client),
        .timeout_limit (tlim),
        .in_valid      (in_valid),
        .in_data       (in_data),
        .in_ready      (in_ready),
        .free_slots    (free_slots),
        .peer_ready    (peer_ready),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .irq_gen       (irq),
        .busy          (busy),
        .done          (done),
        .status        (status)
    );

    // Record slot writes, interrupt pulses and byte acceptances.
    always @(posedge clk) begin
        if (rst_n) begin
            if (wr_en) cap_q.push_back(wr_data);
            if (irq) irqs = irqs + 1;
            acc_flag <= in_valid && in_ready;
        end
    end

    function automatic logic [7:0] pat(int len, int i);
        return 8'((i * 7 + len * 13 + ID * 5) & 255);
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        runs++;
        if (!ok) begin
            fails++;
            $display("FAIL %s (cfg %0d) %s: actual=%0h expected=%0h", req, ID, what, act, exp);
        end
    endtask

    // Drive one message, return the done latency and status.
    task automatic send(int len, logic [7:0] h, logic [7:0] c, int gap, int limit,
                        bit poke, output int lat, output logic [1:0] st);
        int idx;
        idx = 0;
        cap_q.delete();
        irqs = 0;
        @(negedge clk);
        start = 1'b1; msg_len = 16'(len); host = h; client = c; tlim = 24'(limit);
        in_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        lat = 1;
        while (!done && lat < 20000) begin
            if (poke && lat == 3) begin
                start = 1'b1; msg_len = 16'd0;
            end else begin
                start = 1'b0;
            end
            in_valid = (idx < len) && (gap <= 1 || (lat % gap) != 0);
            in_data  = pat(len, idx);
            @(negedge clk);
            lat++;
            if (acc_flag) idx++;
        end
        st = status;
        start = 1'b0;
        in_valid = 1'b0;
        @(posedge clk);
        #1;
    endtask

    // Compare captured slots with the arithmetic expectation.
    task automatic verify(int len, logic [7:0] h, logic [7:0] c, logic [1:0] st);
        int rem, pos, k, nfr, f;
        logic [31:0] exp_w;
        rem = len; pos = 0; k = 0; nfr = 0;
        while (rem > 0) begin
            f = (rem > CAPB) ? CAPB : rem;
            exp_w = {(rem == f), 6'b0, 9'(f), h, c};
            chk(k < cap_q.size() && cap_q[k] == exp_w, "R1 R2", $sformatf("hdr len=%0d", len),
                (k < cap_q.size()) ? cap_q[k] : 0, exp_w);
            k++;
            for (int w = 0; w < (f + 3) / 4; w++) begin
                exp_w = '0;
                for (int b = 0; b < 4; b++)
                    if (4 * w + b < f) exp_w[8*b +: 8] = pat(len, pos + 4 * w + b);
                chk(k < cap_q.size() && cap_q[k] == exp_w, "R4", $sformatf("slot len=%0d", len),
                    (k < cap_q.size()) ? cap_q[k] : 0, exp_w);
                k++;
            end
            pos += f; rem -= f; nfr++;
        end
        chk(cap_q.size() == k, "R2", $sformatf("slot count len=%0d", len), cap_q.size(), k);
        chk(irqs == nfr, "R5", $sformatf("irq count len=%0d", len), irqs, nfr);
        chk(st == 2'd0, "R9", $sformatf("status len=%0d", len), st, 0);
    endtask

    int         lat;
    logic [1:0] st;

    initial begin
        runs = 0; fails = 0; finished = 1'b0; irqs = 0;
        wait (rst_n === 1'b1);
        @(negedge clk);
        // R10: reset state at the ports
        chk(!busy && !done && !wr_en && !irq && !in_ready, "R10", "reset outputs",
            {busy, done, wr_en, irq, in_ready}, 0);
        if (DEPTH <= 8) begin
            // R1 R2 R4 R5 R9: sweep every length across several fragment counts
            for (int len = 1; len <= 3 * CAPB + 4; len++) begin
                send(len, 8'(len * 3), ~8'(len), (len % 3) + 1, 1000, len >= 4, lat, st);
                verify(len, 8'(len * 3), ~8'(len), st);
            end
            // R7: empty message
            send(0, 8'h11, 8'h22, 1, 100, 1'b0, lat, st);
            chk(st == 2'd3 && lat == 1, "R7", "empty status/latency", {st, 8'(lat)}, {2'd3, 8'd1});
            chk(cap_q.size() == 0, "R7", "empty writes", cap_q.size(), 0);
            // R8: timeout waiting for header space
            free_slots = '0;
            send(6, 8'h33, 8'h44, 1, 5, 1'b0, lat, st);
            chk(st == 2'd1 && lat == 7, "R8", "hdr timeout status/latency", {st, 8'(lat)}, {2'd1, 8'd7});
            chk(cap_q.size() == 0 && irqs == 0, "R8", "hdr timeout writes", cap_q.size() + irqs, 0);
            // R8: timeout waiting for payload space after the header
            free_slots = SW'(1);
            send(8, 8'h55, 8'h66, 1, 3, 1'b0, lat, st);
            chk(st == 2'd1 && lat == 6, "R8", "body timeout status/latency", {st, 8'(lat)}, {2'd1, 8'd6});
            chk(cap_q.size() == 1 && cap_q[0] == {1'b1, 6'b0, 9'd8, 8'h55, 8'h66} && irqs == 0,
                "R8", "body timeout header only", cap_q.size(), 1);
            // R3: payload held back until enough slots are free
            free_slots = SW'(1);
            fork
                send(8, 8'h77, 8'h88, 1, 1000, 1'b0, lat, st);
                begin
                    repeat (15) @(negedge clk);
                    chk(cap_q.size() == 1, "R3", "writes while short of space", cap_q.size(), 1);
                    free_slots = SW'(DEPTH);
                end
            join
            verify(8, 8'h77, 8'h88, st);
            // R6: peer not ready ends the transfer after the first fragment
            peer_ready = 1'b0;
            send(20, 8'h99, 8'hAA, 1, 1000, 1'b0, lat, st);
            repeat (5) @(negedge clk);
            chk(st == 2'd2, "R6", "not-ready status", st, 2);
            chk(cap_q.size() == 1 + (CAPB + 3) / 4 && irqs == 1, "R6", "writes before abort",
                cap_q.size(), 1 + (CAPB + 3) / 4);
            peer_ready = 1'b1;
        end else begin
            // R2: cap set by the 9-bit length field
            int lens[7] = '{1, CAPB - 1, CAPB, CAPB + 1, CAPB + 93, 2 * CAPB, 2 * CAPB + 1};
            foreach (lens[i]) begin
                send(lens[i], 8'(i + 5), 8'(200 - i), (i % 2) + 1, 1000, 1'b1, lat, st);
                verify(lens[i], 8'(i + 5), 8'(200 - i), st);
            end
        end
        finished = 1'b1;
    end

endmodule

// File: tb/test_mbox_tx_fragmenter.sv
// Top bench: clock, reset, watchdog and the two configurations.
module test_mbox_tx_fragmenter;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    int   runs_s, fails_s, runs_l, fails_l;
    logic fin_s, fin_l;

    always #4 clk = ~clk;

    mbox_tx_harness #(.DEPTH(4),   .ID(1)) h_small (.clk(clk), .rst_n(rst_n),
        .runs(runs_s), .fails(fails_s), .finished(fin_s));
    mbox_tx_harness #(.DEPTH(200), .ID(2)) h_large (.clk(clk), .rst_n(rst_n),
        .runs(runs_l), .fails(fails_l), .finished(fin_l));

    initial begin
        int cyc;
        int extra;
        extra = 0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cyc = 0;
        while (!(fin_s === 1'b1 && fin_l === 1'b1) && cyc < 190000) begin
            @(posedge clk);
            cyc++;
        end
        if (!(fin_s === 1'b1 && fin_l === 1'b1)) begin
            extra = 1;
            $display("FAIL watchdog: actual=%0d cycles expected=completion", cyc);
        end
        $display("  [TB] %0d tests run, %0d failed", runs_s + runs_l + extra, fails_s + fails_l + extra);
        $finish;
    end

endmodule